// File: doc/BRIEF.md
# Engine-Off Timeout Counter

This block decides when a vehicle controller may treat the engine as switched off for good. While the debounced engine input is low, the block counts slow real-time ticks. When a long count runs out, it clears its engine-state bit and pulses a timeout event for one clock. Lamp logic downstream uses that event to power down.

Counting pauses while the brake or the hazard flasher is active, and it stops for good once the timeout has happened. Every change of the engine input, rising or falling, reloads the full count. A rising edge also sets the engine-state bit again.

The count is held as a chain of bytes. The low byte borrows into the next byte each time it reaches zero. The top byte is preloaded one above its share of the reload value, so expiry is detected when the top byte reaches zero. The reload value is `TIMEOUT_TICKS >> SHRINK`. The default is roughly five minutes of slow ticks, and `SHRINK` cuts it down for short runs.

Top module: `engine_idle_timer`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it, `engineOn` and `timeoutEvt` are 0 and the counter holds the reload preload.
- R2: A cycle with `engToggle` high and `engLevel` high sets `engineOn` to 1 at the next clock edge and reloads the counter.
- R3: A cycle with `engToggle` high and `engLevel` low reloads the counter and leaves `engineOn` unchanged, so the full timeout restarts from that cycle.
- R4: The counter decrements only in a cycle where `slowTick` is 1, `engineOn` is 1, and `engLevel`, `brakeOn`, `hazardOn` and `engToggle` are all 0. In every other cycle it holds.
- R5: Let R = `TIMEOUT_TICKS >> SHRINK`. After a reload, expiry happens on the R-th counting tick if R mod 256 is nonzero, and on the (R+256)-th counting tick if R mod 256 is zero (byte width 8).
- R6: At the clock edge that takes the expiring tick, `engineOn` falls to 0 and `timeoutEvt` rises to 1. `timeoutEvt` stays high for exactly one clock cycle.
- R7: After expiry the counter never wraps or underflows. No further `timeoutEvt` occurs until a rising engine toggle and a fresh full count.
- R8: When `engToggle` and a counting tick fall in the same cycle, the reload wins and no decrement is taken.
- R9: Brake or hazard activity only pauses counting. When both clear, counting resumes from the count held, not from a reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowTick | input | 1 | One-cycle slow real-time tick strobe |
| engToggle | input | 1 | One-cycle event: debounced engine input changed |
| engLevel | input | 1 | Debounced engine input level |
| brakeOn | input | 1 | Brake state bit |
| hazardOn | input | 1 | Hazard flasher state bit |
| engineOn | output | 1 | Engine state bit, cleared on timeout |
| timeoutEvt | output | 1 | One-cycle pulse when the timeout expires |

## Verification
The bench builds the block with `TIMEOUT_TICKS` left at its five-minute default and `SHRINK` set to 7. This gives a reload of 286: the low byte is nonzero and the high byte is preloaded to 2. With that reload, a full expiry, including one borrow from the low byte into the high byte, completes in about 2300 clocks when a tick arrives every eight cycles. That short expiry lets a single run cover several expiries, restarts partway through a count, brake and hazard pauses, and reloads that land on the same cycle as a tick. The zero-low-byte path of R5 needs a different reload value and is not reached in this build.

// File: rtl/engt_pkg.sv
package engt_pkg;
  // Control-to-datapath strobes for the timeout counter.
  typedef struct packed {
    logic load;  // restore the reload preload
    logic dec;   // take one counting tick
  } engt_strobe_t;
endpackage

// File: rtl/engt_datapath.sv
module engt_datapath
  import engt_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2,
  parameter int RELOAD    = 36621
) (
  input  logic         clk,
  input  logic         rstN,
  input  engt_strobe_t strb,
  output logic         expireNow
);
  localparam int CNT_W = BYTE_W * NUM_BYTES;
  localparam int TOP_SHIFT = BYTE_W * (NUM_BYTES - 1);
  // Top byte is preloaded one higher so that expiry shows as top byte reaching zero.
  localparam logic [CNT_W-1:0] PRELOAD = CNT_W'(RELOAD) + (CNT_W'(1) << TOP_SHIFT);

  logic [BYTE_W-1:0] byteQ   [NUM_BYTES];
  logic [BYTE_W-1:0] byteDec [NUM_BYTES];
  logic [NUM_BYTES:0] borrow;
  logic [CNT_W-1:0] cntFlat;

  assign borrow[0] = strb.dec;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_stage
    assign byteDec[g] = byteQ[g] - BYTE_W'(1);
    // A stage passes the borrow upward when it steps down onto zero.
    assign borrow[g+1] = borrow[g] && (byteDec[g] == '0);
    assign cntFlat[g*BYTE_W +: BYTE_W] = byteQ[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        byteQ[g] <= PRELOAD[g*BYTE_W +: BYTE_W];
      end else if (strb.load) begin
        byteQ[g] <= PRELOAD[g*BYTE_W +: BYTE_W];
      end else if (borrow[g]) begin
        byteQ[g] <= byteDec[g];
      end
    end
  end

  assign expireNow = borrow[NUM_BYTES];

  // R4: without a strobe the count holds
  a_r4_hold_count: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.dec) |=> $stable(cntFlat));
  // R7: a counting tick never reaches an already expired counter
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strb.dec |-> (cntFlat[CNT_W-1 -: BYTE_W] != '0));
  // R3: a load restores the full preload
  a_r3_reload_value: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (cntFlat == PRELOAD));
endmodule

// File: rtl/engt_ctrl.sv
module engt_ctrl
  import engt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         slowTick,
  input  logic         engToggle,
  input  logic         engLevel,
  input  logic         brakeOn,
  input  logic         hazardOn,
  input  logic         expireNow,
  output engt_strobe_t strb,
  output logic         engineOn,
  output logic         timeoutEvt
);
  logic idleQualified;

  // Counting needs an engine still marked on, input low, and no lamp activity.
  assign idleQualified = engineOn && !engLevel && !brakeOn && !hazardOn;

  always_comb begin
    strb.load = engToggle;
    strb.dec  = !engToggle && slowTick && idleQualified;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engineOn   <= 1'b0;
      timeoutEvt <= 1'b0;
    end else begin
      timeoutEvt <= 1'b0;
      if (engToggle) begin
        if (engLevel) engineOn <= 1'b1;
      end else if (expireNow) begin
        engineOn   <= 1'b0;
        timeoutEvt <= 1'b1;
      end
    end
  end

  // R6: the event lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    timeoutEvt |=> !timeoutEvt);
  // R6: the event comes with the engine bit falling
  a_r6_evt_clears_engine: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutEvt) |-> ($fell(engineOn)));
  // R4: high engine input blocks expiry
  a_r4_level_blocks: assert property (@(posedge clk) disable iff (!rstN)
    engLevel |=> !timeoutEvt);
  // R9: brake or hazard blocks expiry
  a_r9_lamps_block: assert property (@(posedge clk) disable iff (!rstN)
    (brakeOn || hazardOn) |=> !timeoutEvt);
  // R2: rising toggle turns the engine bit on
  a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rstN)
    (engToggle && engLevel) |=> engineOn);
  // R8: a toggle cycle never produces an event
  a_r8_toggle_priority: assert property (@(posedge clk) disable iff (!rstN)
    engToggle |=> !timeoutEvt);
endmodule

// File: rtl/engine_idle_timer.sv
module engine_idle_timer
  import engt_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 36621,
  parameter int SHRINK        = 0,
  parameter int BYTE_W        = 8,
  parameter int NUM_BYTES     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic slowTick,
  input  logic engToggle,
  input  logic engLevel,
  input  logic brakeOn,
  input  logic hazardOn,
  output logic engineOn,
  output logic timeoutEvt
);
  localparam int RELOAD = TIMEOUT_TICKS >> SHRINK;

  engt_strobe_t strb;
  logic expireNow;

  engt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .engToggle(engToggle),
    .engLevel(engLevel), .brakeOn(brakeOn), .hazardOn(hazardOn),
    .expireNow(expireNow), .strb(strb), .engineOn(engineOn),
    .timeoutEvt(timeoutEvt)
  );

  engt_datapath #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .RELOAD(RELOAD)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .expireNow(expireNow)
  );
endmodule

// File: tb/engine_idle_timer_tb_top.sv
`timescale 1ns/1ps
module engine_idle_timer_tb_top;
  localparam int TO_TICKS = 36621;
  localparam int SHR      = 7;
  localparam int RL       = TO_TICKS >> SHR;
  localparam int EXP_N    = (RL % 256 == 0) ? RL + 256 : RL;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slowTick = 1'b0, engToggle = 1'b0, engLevel = 1'b0;
  logic brakeOn = 1'b0, hazardOn = 1'b0;
  logic engineOn, timeoutEvt;

  always #2.5 clk = ~clk;

  engine_idle_timer #(.TIMEOUT_TICKS(TO_TICKS), .SHRINK(SHR)) dut_i (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .engToggle(engToggle),
    .engLevel(engLevel), .brakeOn(brakeOn), .hazardOn(hazardOn),
    .engineOn(engineOn), .timeoutEvt(timeoutEvt)
  );

  int compared = 0, mismatched = 0;
  int left = 0, divCnt = 0, evtSeen = 0;
  bit mEng = 0, mEvt = 0, started = 0, done = 0;
  bit togReq = 0;
  string curReq = "R1";

  // Behavioural reference: remaining counting ticks until expiry.
  always @(posedge clk) begin
    if (!rstN) begin
      left = EXP_N; mEng = 0; mEvt = 0;
    end else begin
      mEvt = 0;
      if (engToggle) begin
        left = EXP_N;
        if (engLevel) mEng = 1;
      end else if (slowTick && mEng && !engLevel && !brakeOn && !hazardOn) begin
        left = left - 1;
        if (left == 0) begin mEng = 0; mEvt = 1; end
      end
    end
    started = 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic stepOne();
    @(negedge clk);
    if (started) begin
      check(engineOn === mEng, {curReq, " engineOn"}, int'(engineOn), int'(mEng));
      check(timeoutEvt === mEvt, {curReq, " timeoutEvt"}, int'(timeoutEvt), int'(mEvt));
    end
    if (timeoutEvt === 1'b1) evtSeen++;
    divCnt = (divCnt + 1) % 8;
    slowTick = (divCnt == 0);
    engToggle = togReq;
    if (togReq) engLevel = ~engLevel;
    togReq = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) stepOne();
  endtask

  task automatic toggleEng();
    togReq = 1; stepOne(); stepOne();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    run(4);
    check(engineOn === 1'b0 && timeoutEvt === 1'b0, "R1 reset outputs", int'(engineOn), 0);
    rstN = 1'b1;
    stepOne();
    check(engineOn === 1'b0, "R1 after release", int'(engineOn), 0);
    // R2: rising toggle sets engine bit
    curReq = "R2";
    toggleEng();
    check(engineOn === 1'b1, "R2 engine set", int'(engineOn), 1);
    // R4: input high, no counting
    curReq = "R4"; evtSeen = 0;
    run(3000);
    check(evtSeen == 0, "R4 no expiry while input high", evtSeen, 0);
    // R5/R6: falling edge, count to expiry
    curReq = "R5"; evtSeen = 0;
    toggleEng();
    run(EXP_N * 8 + 40);
    check(evtSeen == 1, "R6 one event at expiry", evtSeen, 1);
    check(engineOn === 1'b0, "R6 engine cleared", int'(engineOn), 0);
    // R7: stays expired
    curReq = "R7"; evtSeen = 0;
    run(3000);
    check(evtSeen == 0, "R7 no further events", evtSeen, 0);
    // R3: restart partway through
    curReq = "R3"; evtSeen = 0;
    toggleEng(); toggleEng();
    run(150 * 8);
    toggleEng(); toggleEng();
    run((EXP_N - 20) * 8);
    check(evtSeen == 0, "R3 reload restarted count", evtSeen, 0);
    run(40 * 8);
    check(evtSeen == 1, "R3 expiry after restart", evtSeen, 1);
    // R9: pauses by brake and hazard
    curReq = "R9"; evtSeen = 0;
    toggleEng(); toggleEng();
    run(100 * 8);
    brakeOn = 1'b1; run(400 * 8); brakeOn = 1'b0;
    hazardOn = 1'b1; run(400 * 8); hazardOn = 1'b0;
    check(evtSeen == 0, "R9 paused", evtSeen, 0);
    run((EXP_N - 100) * 8 + 16);
    check(evtSeen == 1, "R9 resumed from held count", evtSeen, 1);
    // R8: toggles landing on tick cycles
    curReq = "R8"; evtSeen = 0;
    for (int k = 0; k < 6; k++) begin
      while (divCnt != 7) stepOne();
      togReq = 1; stepOne();
      check(slowTick === 1'b1 && engToggle === 1'b1, "R8 coincident setup", int'(slowTick), 1);
      run(EXP_N * 4 + 3);
    end
    // R4: random mixed traffic
    curReq = "R4";
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 399) == 0) togReq = 1;
      if ($urandom_range(0, 999) == 0) brakeOn = ~brakeOn;
      if ($urandom_range(0, 1499) == 0) hazardOn = ~hazardOn;
      stepOne();
    end
    done = 1;
    summary();
  end
endmodule